// File: doc/BRIEF.md
# Pre/Post Trigger Capture Controller

This block steers acquired samples into a circular buffer so that a finished capture holds the history leading up to an event and a programmed stretch of data after it. A start command clears the write position and begins acquisition. Every sample strobed in while acquisition runs is stored at the current write address. The address then advances and wraps from the last location back to zero, so older data is overwritten.

The first trigger that coincides with an accepted sample marks that sample as the trigger sample and latches the post-trigger delay. Once that many further samples are stored, acquisition stops and the block reports done. The reported positions are the oldest stored sample, the trigger sample, and whether the buffer wrapped. A synchronous read port lets the consumer fetch the buffer contents afterwards.

Top module: `trig_capture`

## Requirements
- R1: After reset, busy_o, done_o and wrapped_o are 0, oldest_o is 0, and nothing is written.
- R2: start_i takes priority over all other inputs. In the next cycle the write address is 0, wrapped_o and done_o are 0 and busy_o is 1. A sample presented in the start cycle is not stored.
- R3: While busy, each cycle with smp_valid_i high stores smp_data_i at the current write address. The address then increments by one, and after DEPTH-1 it continues at 0.
- R4: A trigger is honoured only in the acquiring phase before any trigger, and only in a cycle where a sample is accepted. That sample is the trigger sample, and delay_i is latched in the same cycle.
- R5: After the trigger sample, exactly the latched delay number of further samples are stored. Then done_o rises, busy_o falls and writes stop. With a delay of 0, done_o rises right after the trigger sample.
- R6: trig_i is ignored in each of these cases: before start, after the first honoured trigger, while done, or without smp_valid_i.
- R7: wrapped_o is set once address DEPTH-1 has been written and holds until the next start. oldest_o equals the next write address when wrapped_o is 1, and 0 otherwise.
- R8: When done, trig_idx_o equals (last written address - latched delay) mod DEPTH, and that location holds the trigger sample.
- R9: rd_data_o shows the buffer word at rd_addr_i one clock after the address is presented.
- R10: done_o, oldest_o and trig_idx_o hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new capture |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | SW | Sample word |
| trig_i | input | 1 | Trigger event |
| delay_i | input | AW | Post-trigger sample count |
| rd_addr_i | input | AW | Buffer read address |
| busy_o | output | 1 | Acquisition in progress |
| done_o | output | 1 | Capture finished |
| wrapped_o | output | 1 | Buffer wrapped at least once |
| oldest_o | output | AW | Address of oldest valid sample |
| trig_idx_o | output | AW | Address of trigger sample |
| rd_data_o | output | SW | Buffer read data |

## Verification
Two functions can fall in the same cycle. The trigger can coincide with the sample it selects, which is also the cycle that may end the capture when the delay is 0. A start can also coincide with a sample strobe. The bench drives both collisions directly. It also produces them at random by raising trigger, strobe and start together. A cycle model predicts the busy, done, wrap and index outputs after every edge. Readback then confirms that the location named by trig_idx_o holds the very sample presented with the trigger.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_ACQ  = 2'd1,
        CAP_POST = 2'd2,
        CAP_DONE = 2'd3
    } cap_state_e;
endpackage

// File: rtl/trig_capture_seq.sv
module trig_capture_seq
    import trig_capture_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          valid_i,
    input  logic          trig_i,
    input  logic [AW-1:0] delay_i,
    output logic          wr_en_o,
    output logic          clr_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] dly_o
);
    typedef struct packed {
        cap_state_e    st;
        logic [AW-1:0] cnt;
        logic [AW-1:0] dly;
    } seq_t;

    seq_t s_d, s_q;
    logic wr_en_d;

    always_comb begin
        s_d     = s_q;
        wr_en_d = 1'b0;
        if (start_i) begin
            s_d.st  = CAP_ACQ;
            s_d.cnt = '0;
            s_d.dly = '0;
        end else begin
            case (s_q.st)
                CAP_ACQ: begin
                    if (valid_i) begin
                        wr_en_d = 1'b1;
                        if (trig_i) begin
                            s_d.dly = delay_i;
                            s_d.cnt = delay_i;
                            s_d.st  = (delay_i == '0) ? CAP_DONE : CAP_POST;
                        end
                    end
                end
                CAP_POST: begin
                    if (valid_i) begin
                        wr_en_d = 1'b1;
                        s_d.cnt = s_q.cnt - 1'b1;
                        if (s_q.cnt == AW'(1)) s_d.st = CAP_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: CAP_IDLE, cnt: '0, dly: '0};
        else        s_q <= s_d;
    end

    assign wr_en_o = wr_en_d;
    assign clr_o   = start_i;
    assign busy_o  = (s_q.st == CAP_ACQ) || (s_q.st == CAP_POST);
    assign done_o  = (s_q.st == CAP_DONE);
    assign dly_o   = s_q.dly;

    // R5
    post_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == CAP_POST) |-> (s_q.cnt != '0));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
endmodule

// File: rtl/trig_capture_wptr.sv
module trig_capture_wptr #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          adv_i,
    output logic [AW-1:0] ptr_o,
    output logic          wrap_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          wrap;
    } wp_t;

    wp_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (clr_i) begin
            w_d.ptr  = '0;
            w_d.wrap = 1'b0;
        end else if (adv_i) begin
            w_d.ptr = w_q.ptr + 1'b1;
            if (w_q.ptr == LAST) w_d.wrap = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{ptr: '0, wrap: 1'b0};
        else        w_q <= w_d;
    end

    assign ptr_o  = w_q.ptr;
    assign wrap_o = w_q.wrap;

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i) |=> (ptr_o == $past(ptr_o) + AW'(1)));

    // R7
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !clr_i) |=> wrap_o);
endmodule

// File: rtl/trig_capture_buf.sv
module trig_capture_buf #(
    parameter int DEPTH = 1024,
    parameter int SW    = 12,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [SW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [SW-1:0] rdata_o
);
    logic [SW-1:0] mem_q [DEPTH];
    logic [SW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
        rdata_q <= mem_q[raddr_i];
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
    parameter int DEPTH = 1024,
    parameter int SW    = 12,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          smp_valid_i,
    input  logic [SW-1:0] smp_data_i,
    input  logic          trig_i,
    input  logic [AW-1:0] delay_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          wrapped_o,
    output logic [AW-1:0] oldest_o,
    output logic [AW-1:0] trig_idx_o,
    output logic [SW-1:0] rd_data_o
);
    logic          wr_en, clr;
    logic [AW-1:0] ptr, dly;

    trig_capture_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(smp_valid_i),
        .trig_i(trig_i), .delay_i(delay_i), .wr_en_o(wr_en), .clr_o(clr),
        .busy_o(busy_o), .done_o(done_o), .dly_o(dly)
    );

    trig_capture_wptr #(.DEPTH(DEPTH)) u_wptr (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .adv_i(wr_en),
        .ptr_o(ptr), .wrap_o(wrapped_o)
    );

    trig_capture_buf #(.DEPTH(DEPTH), .SW(SW)) u_buf (
        .clk(clk), .we_i(wr_en), .waddr_i(ptr), .wdata_i(smp_data_i),
        .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
    );

    assign oldest_o   = wrapped_o ? ptr : '0;
    assign trig_idx_o = ptr - AW'(1) - dly;

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !done_o && !wrapped_o && oldest_o == '0));

    // R5
    frozen_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(oldest_o) && $stable(trig_idx_o) && !busy_o));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(oldest_o));
endmodule

// File: tb/trig_capture_bench.sv
module trig_capture_bench;
    localparam int DEPTH = 16;
    localparam int SW    = 12;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, valid = 1'b0, trig = 1'b0;
    logic [SW-1:0] data = '0;
    logic [AW-1:0] delay = '0, rd_addr = '0;
    logic          busy, done, wrapped;
    logic [AW-1:0] oldest, tidx;
    logic [SW-1:0] rd_data;

    int errors = 0;
    int checks = 0;

    int m_st = 0;
    int m_ptr = 0, m_cnt = 0, m_dly = 0, m_trig_data = 0;
    bit m_wrap = 0;
    int m_mem [DEPTH];
    bit m_wr [DEPTH];

    always #5 clk = ~clk;

    trig_capture #(.DEPTH(DEPTH), .SW(SW)) u_trig_capture (
        .clk(clk), .rst_n(rst_n), .start_i(start), .smp_valid_i(valid),
        .smp_data_i(data), .trig_i(trig), .delay_i(delay), .rd_addr_i(rd_addr),
        .busy_o(busy), .done_o(done), .wrapped_o(wrapped), .oldest_o(oldest),
        .trig_idx_o(tidx), .rd_data_o(rd_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_oldest();
        return m_wrap ? m_ptr : 0;
    endfunction

    function automatic int exp_tidx();
        return (m_ptr - 1 - m_dly) & (DEPTH - 1);
    endfunction

    task automatic model_write(input int d);
        m_mem[m_ptr] = d;
        m_wr[m_ptr] = 1'b1;
        if (m_ptr == DEPTH - 1) m_wrap = 1'b1;
        m_ptr = (m_ptr + 1) & (DEPTH - 1);
    endtask

    task automatic step(input bit s, input bit v, input bit t, input int dl);
        @(negedge clk);
        start = s; valid = v; trig = t;
        data = SW'($urandom);
        delay = AW'(dl);
        @(posedge clk);
        if (s) begin
            m_st = 1; m_ptr = 0; m_wrap = 0; m_cnt = 0; m_dly = 0;
        end else if (m_st == 1 && v) begin
            if (t) begin
                m_trig_data = int'(data);
                m_dly = dl; m_cnt = dl;
                m_st = (dl == 0) ? 3 : 2;
            end
            model_write(int'(data));
        end else if (m_st == 2 && v) begin
            model_write(int'(data));
            m_cnt--;
            if (m_cnt == 0) m_st = 3;
        end
        #1;
        check("R2 busy", int'(busy), int'(m_st == 1 || m_st == 2));
        check("R5 done", int'(done), int'(m_st == 3));
        check("R7 wrapped", int'(wrapped), int'(m_wrap));
        check("R7 oldest", int'(oldest), exp_oldest());
        if (m_st == 3) check("R8 trig_idx", int'(tidx), exp_tidx());
        @(negedge clk);
        start = 0; valid = 0; trig = 0;
    endtask

    task automatic read_back();
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            rd_addr = AW'(a);
            @(posedge clk);
            #1;
            if (m_wr[a]) check("R9 readback", int'(rd_data), m_mem[a]);
        end
        @(negedge clk);
        rd_addr = AW'(exp_tidx());
        @(posedge clk);
        #1;
        check("R8 trigger sample", int'(rd_data), m_trig_data);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 wrapped", int'(wrapped), 0);
        check("R1 oldest", int'(oldest), 0);
        @(negedge clk); rst_n = 1'b1;

        // R6 trigger before start ignored
        step(0, 1, 1, 3);
        check("R6 pre-start trig", int'(done), 0);

        // R2 start collides with a sample: not stored
        step(1, 1, 0, 0);
        // short capture, no wrap, delay 2; trig without valid ignored (R6)
        step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        step(0, 1, 1, 2);   // R4 trigger with sample
        step(0, 1, 1, 9);   // R6 second trigger ignored
        step(0, 1, 0, 0);   // R5 last post sample
        check("R5 done after delay", int'(done), 1);
        check("R7 no wrap oldest", int'(oldest), 0);
        step(0, 1, 1, 1);   // R10 stimulus while done ignored
        check("R10 done hold", int'(done), 1);
        read_back();

        // R5 zero delay stops on trigger sample
        step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        step(0, 1, 1, 0);
        check("R5 zero delay", int'(done), 1);
        read_back();

        // R3 R7 wrapping capture with maximum delay
        step(1, 0, 0, 0);
        for (int i = 0; i < 40; i++) step(0, 1, 0, 0);
        step(0, 1, 1, DEPTH - 1);
        for (int i = 0; i < DEPTH - 1; i++) step(0, 1, 0, 0);
        check("R7 wrap", int'(wrapped), 1);
        read_back();

        // random captures
        for (int c = 0; c < 25; c++) begin
            step(1, ($urandom % 2) == 0, 0, 0);
            for (int n = 0; n < 400 && m_st != 3; n++) begin
                step(($urandom % 300) == 0, ($urandom % 10) < 7,
                     ($urandom % 12) == 0, int'($urandom % DEPTH));
            end
            if (m_st == 3) read_back();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule